// File: doc/BRIEF.md
# Network Controller Host Register Block

This block is the host-facing register file of a network controller. The host first loads a small register pointer, then reads or writes the selected register through one data port with separate read and write strobes. Three registers can be selected. The main control/status register carries four control bits. Two address registers together hold the 24-bit start address of the initialization block in controller memory.

The control bits can only be set by writing a one; a zero never clears them. Stopping the device wins over every other request, and it clears run, initialize and transmit demand. Leaving the stopped state requires a write of initialize or run while the device is stopped. The internal engine clears a pending transmit demand with an acknowledge input. An accepted initialize request produces a single-cycle pulse toward that engine.

The address registers are protected: they accept writes and return data only while the device is stopped, and they keep their contents across stop. The value returned on a read is captured when the read strobe rises, so the data stays stable for as long as the strobe is held.

Top module: `nctl_regs`

## Requirements
- R1: After reset, stop is 1; run, initialize, transmit demand and the init-request pulse are 0; both address registers are 0; the read data is 0.
- R2: The main register (pointer 0) reads with initialize in bit 0, run in bit 1, stop in bit 2, transmit demand in bit 3, and zero in bits 15:4. Writing 0 to any of these bits leaves it unchanged.
- R3: A write with bit 2 set leaves only stop set and clears initialize, run and transmit demand, whatever the other written bits are.
- R4: A write with bit 0 or bit 1 set (and bit 2 clear) sets those bits and clears stop only when stop was already 1 before the write. Otherwise initialize and run are left unchanged.
- R5: An accepted initialize write raises init_req_o for exactly one cycle. Initialize then reads as 1 until reset or stop.
- R6: A write with bit 3 set (and bit 2 clear) sets transmit demand. A cycle with tdmd_ack high and no such write clears it. When a set and an acknowledge arrive in the same cycle, the demand stays set.
- R7: Address register 1 (pointer 1) stores written bits 15:1, and its bit 0 always reads 0.
- R8: Address register 2 (pointer 2) stores written bits 7:0, and its bits 15:8 always read 0.
- R9: While stop is 0, writes to the address registers are dropped and reads of them return 0. Their contents survive setting stop.
- R10: Read data is captured on the cycle host_rd rises and is held unchanged while host_rd stays high, even if the register contents change.
- R11: The pointer takes host_wdata[1:0] on host_ptr_we. Pointer value 3 reads 0, and writes to it change nothing.
- R12: init_addr_o presents the 24-bit address, formed from register 2 bits 7:0 as bits 23:16 and register 1 bits 15:1 as bits 15:1, with bit 0 at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_ptr_we | input | 1 | Load register pointer from host_wdata[1:0] |
| host_wr | input | 1 | Write host_wdata to the selected register |
| host_rd | input | 1 | Read strobe; data captured on its rising cycle |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Latched read data |
| tdmd_ack | input | 1 | Engine acknowledge that consumes transmit demand |
| run_o | output | 1 | Run state |
| stopped_o | output | 1 | Stop state |
| tdmd_o | output | 1 | Pending transmit demand |
| init_req_o | output | 1 | One-cycle initialization request |
| init_addr_o | output | 24 | Initialization block address |

## Verification
The bench builds the block with its default 16-bit data port and 24-bit address. With these values, every one of the 16 control nibbles can be written from each of four starting states (stopped, running, initialized, running with a demand pending), and the outcome is compared against an arithmetic model. The small width also allows a walking-one sweep over all 16 data bits of both address registers. Directed sequences cover the pointer lock while running, a demand set and acknowledged in the same cycle, and a status change during a held read.

// File: rtl/nctl_pkg.sv
package nctl_pkg;

  typedef enum logic [1:0] {
    SEL_MAIN = 2'd0,
    SEL_ALO  = 2'd1,
    SEL_AHI  = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  // bit order fixed by the main register layout: [3]=tdmd [2]=stop [1]=strt [0]=init
  typedef struct packed {
    logic tdmd;
    logic stop;
    logic strt;
    logic init;
  } ctl_t;

  localparam ctl_t CTL_STOPPED = '{tdmd: 1'b0, stop: 1'b1, strt: 1'b0, init: 1'b0};

  // next control state from current state, written nibble (zero when no write) and ack
  function automatic ctl_t ctl_next(ctl_t cur, ctl_t w, logic ack);
    ctl_t n;
    n = cur;
    if (ack) n.tdmd = 1'b0;
    if (w.stop) begin
      n = CTL_STOPPED;
    end else begin
      if (cur.stop && (w.init || w.strt)) begin
        n.stop = 1'b0;
        n.init = w.init;
        n.strt = w.strt;
      end
      if (w.tdmd) n.tdmd = 1'b1;
    end
    return n;
  endfunction

endpackage

// File: rtl/nctl_ctrl.sv
module nctl_ctrl
  import nctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_main,
  input  ctl_t wbits,
  input  logic tdmd_ack,
  output ctl_t st,
  output logic init_req
);

  ctl_t w_eff;
  ctl_t st_nx;
  logic init_accept;

  assign w_eff       = wr_main ? wbits : '0;
  assign st_nx       = ctl_next(st, w_eff, tdmd_ack);
  assign init_accept = wr_main && st.stop && wbits.init && !wbits.stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= CTL_STOPPED;
      init_req <= 1'b0;
    end else begin
      st       <= st_nx;
      init_req <= init_accept;
    end
  end

  p_stop_override_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_main && wbits.stop |=> st.stop && !st.strt && !st.init && !st.tdmd);

  p_ignore_running_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_main && !st.stop && !wbits.stop |=> !st.stop && $stable(st.init) && $stable(st.strt));

  p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    init_req |=> !init_req);

  p_pulse_init_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    init_req |-> st.init && !st.stop);

  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tdmd_ack && !(wr_main && wbits.tdmd) |=> !st.tdmd);

  p_run_stop_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(st.strt && st.stop));

endmodule

// File: rtl/nctl_addr.sv
module nctl_addr #(
  parameter int DW  = 16,
  parameter int IAW = 24,
  localparam int LO_W = DW - 1,
  localparam int HI_W = IAW - DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [DW-1:0]   wdata,
  input  logic            stopped,
  output logic [LO_W-1:0] lo_q,
  output logic [HI_W-1:0] hi_q
);

  logic lo_we;
  logic hi_we;

  assign lo_we = wr_lo && stopped;
  assign hi_we = wr_hi && stopped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (lo_we) lo_q <= wdata[DW-1:1];
      if (hi_we) hi_q <= wdata[HI_W-1:0];
    end
  end

  p_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo || wr_hi) && !stopped |=> $stable(lo_q) && $stable(hi_q));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lo && !wr_hi |=> $stable(lo_q) && $stable(hi_q));

endmodule

// File: rtl/nctl_rdport.sv
module nctl_rdport
  import nctl_pkg::*;
#(
  parameter int DW  = 16,
  parameter int IAW = 24,
  localparam int LO_W = DW - 1,
  localparam int HI_W = IAW - DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_stb,
  input  sel_e            sel,
  input  ctl_t            st,
  input  logic [LO_W-1:0] lo_q,
  input  logic [HI_W-1:0] hi_q,
  output logic [DW-1:0]   rdata
);

  logic          rd_q;
  logic          rd_start;
  logic [DW-1:0] view;

  function automatic logic [DW-1:0] reg_view(sel_e s, ctl_t c,
                                             logic [LO_W-1:0] lo, logic [HI_W-1:0] hi);
    logic [DW-1:0] v;
    v = '0;
    unique case (s)
      SEL_MAIN: v = {{(DW-4){1'b0}}, c};
      SEL_ALO:  v = c.stop ? {lo, 1'b0} : '0;
      SEL_AHI:  v = c.stop ? {{(DW-HI_W){1'b0}}, hi} : '0;
      default:  v = '0;
    endcase
    return v;
  endfunction

  assign rd_start = rd_stb && !rd_q;
  assign view     = reg_view(sel, st, lo_q, hi_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      rdata <= '0;
    end else begin
      rd_q <= rd_stb;
      if (rd_start) rdata <= view;
    end
  end

  p_read_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && rd_q |=> $stable(rdata));

  p_gated_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start && !st.stop && sel != SEL_MAIN |=> rdata == '0);

  p_none_reads_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start && sel == SEL_NONE |=> rdata == '0);

endmodule

// File: rtl/nctl_regs.sv
module nctl_regs
  import nctl_pkg::*;
#(
  parameter int DW  = 16,
  parameter int IAW = 24,
  localparam int LO_W = DW - 1,
  localparam int HI_W = IAW - DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_ptr_we,
  input  logic           host_wr,
  input  logic           host_rd,
  input  logic [DW-1:0]  host_wdata,
  output logic [DW-1:0]  host_rdata,
  input  logic           tdmd_ack,
  output logic           run_o,
  output logic           stopped_o,
  output logic           tdmd_o,
  output logic           init_req_o,
  output logic [IAW-1:0] init_addr_o
);

  sel_e            ptr_q;
  ctl_t            st;
  ctl_t            wbits;
  logic            wr_main;
  logic            wr_lo;
  logic            wr_hi;
  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ptr_q <= SEL_MAIN;
    else if (host_ptr_we) ptr_q <= sel_e'(host_wdata[1:0]);
  end

  assign wr_main = host_wr && (ptr_q == SEL_MAIN);
  assign wr_lo   = host_wr && (ptr_q == SEL_ALO);
  assign wr_hi   = host_wr && (ptr_q == SEL_AHI);
  assign wbits   = ctl_t'(host_wdata[3:0]);

  nctl_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_main  (wr_main),
    .wbits    (wbits),
    .tdmd_ack (tdmd_ack),
    .st       (st),
    .init_req (init_req_o)
  );

  nctl_addr #(.DW(DW), .IAW(IAW)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_lo   (wr_lo),
    .wr_hi   (wr_hi),
    .wdata   (host_wdata),
    .stopped (st.stop),
    .lo_q    (lo_q),
    .hi_q    (hi_q)
  );

  nctl_rdport #(.DW(DW), .IAW(IAW)) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_stb (host_rd),
    .sel    (ptr_q),
    .st     (st),
    .lo_q   (lo_q),
    .hi_q   (hi_q),
    .rdata  (host_rdata)
  );

  assign run_o       = st.strt;
  assign stopped_o   = st.stop;
  assign tdmd_o      = st.tdmd;
  assign init_addr_o = {hi_q, lo_q, 1'b0};

  p_ptr3_inert_r11: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && ptr_q == SEL_NONE && !tdmd_ack |=> $stable(st) && $stable(init_addr_o));

endmodule

// File: tb/nctl_regs_test.sv
module nctl_regs_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_ptr_we = 1'b0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        tdmd_ack = 1'b0;
  logic        run_o, stopped_o, tdmd_o, init_req_o;
  logic [23:0] init_addr_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nctl_regs uut (
    .clk(clk), .rst_n(rst_n), .host_ptr_we(host_ptr_we), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tdmd_ack(tdmd_ack), .run_o(run_o), .stopped_o(stopped_o), .tdmd_o(tdmd_o),
    .init_req_o(init_req_o), .init_addr_o(init_addr_o)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic set_ptr(int p);
    @(negedge clk); host_ptr_we = 1'b1; host_wdata = 16'(p);
    @(negedge clk); host_ptr_we = 1'b0;
  endtask

  task automatic wr(int d);
    @(negedge clk); host_wr = 1'b1; host_wdata = 16'(d);
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd(output int d);
    @(negedge clk); host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0; d = int'(host_rdata);
  endtask

  // bench model of the control nibble: returns state after writing v
  function automatic int model(int cur, int v);
    int n;
    if ((v & 4) != 0) return 4;
    n = cur;
    if ((cur & 4) != 0 && (v & 3) != 0) n = (n & 8) | (v & 3);
    if ((v & 8) != 0) n = n | 8;
    return n;
  endfunction

  function automatic int outs();
    return {tdmd_o, stopped_o, run_o};
  endfunction

  function automatic int outs_of(int s);
    return (((s >> 3) & 1) << 2) | (((s >> 2) & 1) << 1) | ((s >> 1) & 1);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int d;
    int cur;
    int nx;
    int pl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 outs", outs(), 3'b010);
    chk("R1 init_req", int'(init_req_o), 0);
    chk("R1 rdata", int'(host_rdata), 0);
    chk("R1 addr", int'(init_addr_o), 0);
    rd(d); chk("R1 R2 main read", d, 4);

    // R7 R8 R12 walking ones while stopped
    for (int i = 0; i < 16; i++) begin
      set_ptr(1); wr(1 << i); rd(d);
      chk("R7 lo walk", d, (1 << i) & 16'hFFFE);
      set_ptr(2); wr(1 << i); rd(d);
      chk("R8 hi walk", d, (1 << i) & 16'h00FF);
    end
    set_ptr(1); wr(16'h1235); rd(d); chk("R7 bit0 zero", d, 16'h1234);
    set_ptr(2); wr(16'hABCD); rd(d); chk("R8 reserved zero", d, 16'h00CD);
    chk("R12 init_addr", int'(init_addr_o), 24'hCD1234);

    // R11 pointer 3 inert
    set_ptr(3); wr(16'hFFFF); rd(d); chk("R11 ptr3 read", d, 0);
    chk("R11 ptr3 no effect outs", outs(), 3'b010);
    chk("R11 ptr3 no effect addr", int'(init_addr_o), 24'hCD1234);

    // R9 lock while running
    set_ptr(0); wr(2);
    chk("R4 start", outs(), 3'b001);
    set_ptr(1); wr(16'hFFFF); rd(d); chk("R9 gated lo read", d, 0);
    set_ptr(2); wr(16'h00FF); rd(d); chk("R9 gated hi read", d, 0);
    chk("R9 write dropped", int'(init_addr_o), 24'hCD1234);
    set_ptr(0); wr(4);
    set_ptr(1); rd(d); chk("R9 kept over stop", d, 16'h1234);
    set_ptr(2); rd(d); chk("R9 kept over stop hi", d, 16'h00CD);

    // R2 R3 R4 R5 R6 sweep over start states and all nibbles
    set_ptr(0);
    for (int s = 0; s < 4; s++) begin
      for (int v = 0; v < 16; v++) begin
        wr(4); cur = 4;
        if (s == 1 || s == 3) begin wr(2); cur = model(cur, 2); end
        if (s == 2) begin wr(1); cur = model(cur, 1); end
        if (s == 3) begin wr(8); cur = model(cur, 8); end
        nx = model(cur, v);
        pl = ((cur & 4) != 0 && (v & 1) != 0 && (v & 4) == 0) ? 1 : 0;
        wr(v);
        chk("R5 init pulse", int'(init_req_o), pl);
        chk("R3 R4 R6 outs", outs(), outs_of(nx));
        rd(d);
        chk("R2 main read", d, nx);
        chk("R5 pulse single", int'(init_req_o), 0);
      end
    end

    // R6 acknowledge and simultaneous set
    wr(4); wr(2); wr(8);
    chk("R6 set", int'(tdmd_o), 1);
    @(negedge clk); tdmd_ack = 1'b1;
    @(negedge clk); tdmd_ack = 1'b0;
    chk("R6 ack clears", int'(tdmd_o), 0);
    @(negedge clk); tdmd_ack = 1'b1; host_wr = 1'b1; host_wdata = 16'h8;
    @(negedge clk); tdmd_ack = 1'b0; host_wr = 1'b0;
    chk("R6 set wins over ack", int'(tdmd_o), 1);

    // R10 read latch held across a status change
    @(negedge clk); host_rd = 1'b1;
    @(negedge clk);
    chk("R10 captured", int'(host_rdata), 16'hA);
    tdmd_ack = 1'b1;
    @(negedge clk); tdmd_ack = 1'b0;
    @(negedge clk);
    chk("R10 status changed", int'(tdmd_o), 0);
    chk("R10 held", int'(host_rdata), 16'hA);
    host_rd = 1'b0;
    rd(d); chk("R10 new read", d, 16'h2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule